// File: doc/BRIEF.md
# Multidrop 9-bit Serial Receiver

This block receives frames from a shared serial line on which many stations listen and one talks. Each frame carries eight data bits followed by a ninth bit that marks the byte as a station address (1) or ordinary data (0). That ninth bit sits where a parity bit would otherwise go. The line is sampled on a 16x oversampling tick supplied from outside, and the receiver rebuilds each frame from those samples.

Software reaches the block through a small register port with read and write strobes. A station normally runs with the address filter on, so every data frame is dropped in hardware and only address bytes reach the receive buffer. Software compares each address with its own. On a match it turns the filter off and takes the data that follows. Words go into a 32-bit receive buffer, either one word per read or packed two per read. In packed mode a sync strobe lets software put the next word back into the lower half.

An address-detect interrupt is raised for every address word accepted, in both modes. The data-ready bit, which also drives the receive interrupt, tells software whether that address sits in the lower or upper half of the packed buffer.

Top module: `mdrop_rx`

## Requirements
- R1: A frame is a low start bit, 8 data bits sent LSB first, the address flag, then a high stop bit, with each bit lasting 16 ticks of `os_tick`. A start bit counts only if the line is still low at the middle of the start bit, so a shorter low pulse leaves all state unchanged.
- R2: With packing off, an accepted frame is written to the buffer (register address 2) as bits [7:0] = data, bit 8 = flag, and all other bits zero. It also sets data-ready (status bit 0), and `irq_rx` follows data-ready.
- R3: While the filter (control bit 2) is 1, a frame whose flag is 0 is discarded. The buffer and the status bits stay unchanged.
- R4: While the filter is 0, every frame with a good stop bit is accepted, whatever its flag.
- R5: Each accepted frame whose flag is 1 sets address-detect (status bit 3 and `irq_addr`), with packing on or off.
- R6: With packing (control bit 3) on, the first word goes to bits [15:0] and the upper half is zeroed. The second word goes to bits [31:16]. Data-ready is set only when the upper half is written.
- R7: In packed mode, data-ready reads 0 after an address word lands in the lower half and 1 after one lands in the upper half.
- R8: Writing 1 to control bit 1 sends the next accepted word to the lower half and drops any half-filled word. The bit always reads back 0.
- R9: Reading the buffer clears data-ready and address-detect. Reading status (address 1) leaves data-ready unchanged.
- R10: A word written to the buffer while data-ready is 1 sets overrun (status bit 1), and the newer word replaces the old one. Overrun is cleared when status is read.
- R11: A stop bit sampled low sets the framing flag (status bit 2) and discards the frame. The flag is cleared when status is read.
- R12: After reset all registers read 0. While enable (control bit 0) is 0, traffic on the line has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial input, already synchronised, idles high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reads have side effects) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 buffer |
| bus_wdata | input | 4 | Control write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| irq_rx | output | 1 | Receive interrupt (data-ready level) |
| irq_addr | output | 1 | Address-detect interrupt level |

## Verification
A buffer read and the arrival of a new word can land on the same clock edge. The design lets the new word win: data-ready stays set and no overrun is flagged, because the old word was consumed. A sync strobe and an accepted word can also coincide, and the word then counts as the first word after the sync. The checker covers these cases directly, by conditioning its read-clear and overrun properties on whether a word was accepted in that cycle. The bench brings about the sync/packing ordering through the register port and judges the result from the packed buffer value and the data-ready bit.

// File: rtl/mdrop_pkg.sv
`timescale 1ns/1ps
// Shared types and register layout for the multidrop receiver.
// Assumes a single clock domain; the bus and line inputs are synchronous.
package mdrop_pkg;
    localparam int DATA_W = 8;

    // One received character: address flag above the data byte.
    typedef struct packed {
        logic              flag;
        logic [DATA_W-1:0] data;
    } mdrop_word_t;

    localparam int WORD_W = $bits(mdrop_word_t);

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_BITS,
        S_STOP
    } rx_state_t;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_BUF  = 2'd2;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_SYNC = 1;
    localparam int CTRL_FILT = 2;
    localparam int CTRL_PACK = 3;
    localparam int CTRL_W    = 4;
endpackage

// File: rtl/mdrop_rx_deser.sv
`timescale 1ns/1ps
// Oversampled deserialiser. It finds a falling edge, confirms the start bit
// at its midpoint, then samples the data bits, the flag and the stop bit at
// their centres. Assumes rx is already synchronised and os_tick is one cycle
// wide. Emits a one-cycle frame strobe carrying the word and a stop-bit error.
module mdrop_rx_deser
    import mdrop_pkg::*;
#(
    parameter int OS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        os_tick,
    input  logic        rx,
    output logic        frm_valid,
    output mdrop_word_t frm_word,
    output logic        frm_ferr
);
    localparam int CW   = $clog2(OS);
    localparam int HALF = OS / 2;
    localparam int BW   = $clog2(DATA_W + 1);

    rx_state_t         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx;
    logic [WORD_W-1:0] shreg;

    // Frame state machine: start check, bit sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            frm_valid <= 1'b0;
            frm_word  <= '0;
            frm_ferr  <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (!enable) begin
                state <= S_IDLE;
            end else if (os_tick) begin
                case (state)
                    S_IDLE: begin
                        if (!rx) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            cnt  <= '0;
                            bidx <= '0;
                            state <= rx ? S_IDLE : S_BITS;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_BITS: begin
                        if (cnt == CW'(OS - 1)) begin
                            cnt   <= '0;
                            shreg <= {rx, shreg[WORD_W-1:1]};
                            if (bidx == BW'(DATA_W)) state <= S_STOP;
                            else                     bidx  <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == CW'(OS - 1)) begin
                            frm_valid <= 1'b1;
                            frm_ferr  <= !rx;
                            frm_word  <= shreg;
                            state     <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdrop_rx_store.sv
`timescale 1ns/1ps
// Acceptance filter, packing and receive buffer. It drops data frames while
// the filter is on, places words in the whole buffer or in one of its halves,
// and keeps the data-ready, overrun, framing and address-detect flags.
// Assumes frm_valid is a one-cycle strobe. When a word arrives in the same
// cycle as a read or a clear, the word's update wins.
module mdrop_rx_store
    import mdrop_pkg::*;
#(
    parameter int BUF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_valid,
    input  mdrop_word_t      frm_word,
    input  logic             frm_ferr,
    input  logic             afilt,
    input  logic             pack,
    input  logic             sync,
    input  logic             rd_buf,
    input  logic             rd_stat,
    output logic [BUF_W-1:0] rxbuf,
    output logic             acc_we,
    output logic             dr,
    output logic             ovr,
    output logic             ferr,
    output logic             adet
);
    localparam int HW = BUF_W / 2;

    logic          upper;
    logic          eff_upper;
    logic          word_done;
    logic [HW-1:0] ext;

    // Acceptance, effective half-word select and word completion.
    always_comb begin
        acc_we    = frm_valid && !frm_ferr && (!afilt || frm_word.flag);
        eff_upper = pack && !sync && upper;
        word_done = acc_we && (!pack || eff_upper);
        ext       = {{(HW - WORD_W){1'b0}}, frm_word};
    end

    // Half-word pointer and buffer contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper <= 1'b0;
            rxbuf <= '0;
        end else begin
            if (!pack)       upper <= 1'b0;
            else if (acc_we) upper <= !eff_upper;
            else if (sync)   upper <= 1'b0;
            if (acc_we) begin
                if (!pack)          rxbuf <= {{(BUF_W - WORD_W){1'b0}}, frm_word};
                else if (eff_upper) rxbuf[BUF_W-1:HW] <= ext;
                else                rxbuf <= {{(BUF_W - HW){1'b0}}, ext};
            end
        end
    end

    // Status flags: sets take precedence over read clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr   <= 1'b0;
            ovr  <= 1'b0;
            ferr <= 1'b0;
            adet <= 1'b0;
        end else begin
            if (word_done)   dr <= 1'b1;
            else if (rd_buf) dr <= 1'b0;
            if (acc_we && dr && !rd_buf) ovr <= 1'b1;
            else if (rd_stat)            ovr <= 1'b0;
            if (frm_valid && frm_ferr) ferr <= 1'b1;
            else if (rd_stat)          ferr <= 1'b0;
            if (acc_we && frm_word.flag) adet <= 1'b1;
            else if (rd_buf)             adet <= 1'b0;
        end
    end
endmodule

// File: rtl/mdrop_rx.sv
`timescale 1ns/1ps
// Top level of the multidrop receiver. It holds the control register,
// decodes the read and write strobes and muxes the read data. It assumes
// one strobe per access; a read's side effects happen on the edge that
// ends the strobe.
module mdrop_rx
    import mdrop_pkg::*;
#(
    parameter int OS    = 16,
    parameter int BUF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [BUF_W-1:0]  bus_rdata,
    output logic              irq_rx,
    output logic              irq_addr
);
    logic             rxen, afilt, pack, sync;
    logic             rd_buf, rd_stat;
    logic             frm_valid, frm_ferr, acc_we;
    mdrop_word_t      frm_word;
    logic [BUF_W-1:0] rxbuf;
    logic             dr, ovr, ferr, adet;

    // Strobe decode for the sync pulse and the read side effects.
    always_comb begin
        sync    = bus_wr && bus_addr == REG_CTRL && bus_wdata[CTRL_SYNC];
        rd_buf  = bus_rd && bus_addr == REG_BUF;
        rd_stat = bus_rd && bus_addr == REG_STAT;
    end

    // Control register; the sync bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxen  <= 1'b0;
            afilt <= 1'b0;
            pack  <= 1'b0;
        end else if (bus_wr && bus_addr == REG_CTRL) begin
            rxen  <= bus_wdata[CTRL_EN];
            afilt <= bus_wdata[CTRL_FILT];
            pack  <= bus_wdata[CTRL_PACK];
        end
    end

    mdrop_rx_deser #(.OS(OS)) i_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rxen),
        .os_tick   (os_tick),
        .rx        (rx_line),
        .frm_valid (frm_valid),
        .frm_word  (frm_word),
        .frm_ferr  (frm_ferr)
    );

    mdrop_rx_store #(.BUF_W(BUF_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_word  (frm_word),
        .frm_ferr  (frm_ferr),
        .afilt     (afilt),
        .pack      (pack),
        .sync      (sync),
        .rd_buf    (rd_buf),
        .rd_stat   (rd_stat),
        .rxbuf     (rxbuf),
        .acc_we    (acc_we),
        .dr        (dr),
        .ovr       (ovr),
        .ferr      (ferr),
        .adet      (adet)
    );

    // Read data mux.
    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = BUF_W'({pack, afilt, 1'b0, rxen});
            REG_STAT: bus_rdata = BUF_W'({adet, ferr, ovr, dr});
            REG_BUF:  bus_rdata = rxbuf;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_rx   = dr;
    assign irq_addr = adet;
endmodule

// File: rtl/mdrop_rx_chk.sv
`timescale 1ns/1ps
// Property checker for mdrop_rx, attached through bind below.
module mdrop_rx_chk #(
    parameter int BUF_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic [1:0]       bus_addr,
    input logic             rd_sync_bit,
    input logic             frm_valid,
    input logic             frm_ferr,
    input logic             frm_flag,
    input logic             afilt,
    input logic             acc_we,
    input logic             rd_buf,
    input logic             dr,
    input logic             ovr,
    input logic             ferr,
    input logic             adet,
    input logic [BUF_W-1:0] rxbuf
);
    p_filter_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && !frm_ferr && afilt && !frm_flag |=> $stable(rxbuf));

    p_addr_detect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we && frm_flag |=> adet);

    p_sync_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == 2'd0 |-> !rd_sync_bit);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_buf && !acc_we |=> !dr && !adet);

    p_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we && dr && !rd_buf |=> ovr);

    p_framing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && frm_ferr |=> ferr && $stable(rxbuf));
endmodule

bind mdrop_rx mdrop_rx_chk #(.BUF_W(BUF_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .rd_sync_bit (bus_rdata[1]),
    .frm_valid   (frm_valid),
    .frm_ferr    (frm_ferr),
    .frm_flag    (frm_word.flag),
    .afilt       (afilt),
    .acc_we      (acc_we),
    .rd_buf      (rd_buf),
    .dr          (dr),
    .ovr         (ovr),
    .ferr        (ferr),
    .adet        (adet),
    .rxbuf       (rxbuf)
);

// File: tb/test_mdrop_rx.sv
`timescale 1ns/1ps
module test_mdrop_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        os_tick = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [3:0]  bus_wdata = 4'd0;
    logic [31:0] bus_rdata;
    logic        irq_rx, irq_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mdrop_rx i_mdrop_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .os_tick   (os_tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_rx    (irq_rx),
        .irq_addr  (irq_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic f, input logic stop);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (16) @(negedge clk);
        end
        rx_line = f;
        repeat (16) @(negedge clk);
        rx_line = stop;
        repeat (16) @(negedge clk);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // Control encodings: bit0 enable, bit1 sync, bit2 filter, bit3 packing.
    localparam logic [3:0] C_EN   = 4'h1;
    localparam logic [3:0] C_FILT = 4'h5;
    localparam logic [3:0] C_PACK = 4'h9;
    localparam logic [3:0] C_SYNC = 4'hB;

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk_reg("R12 status after reset", 2'd1, 32'h0);
        chk_reg("R12 ctrl after reset", 2'd0, 32'h0);
        chk_reg("R12 buffer after reset", 2'd2, 32'h0);
        check("R12 irq after reset", {irq_rx, irq_addr}, 0);
        // R12: disabled receiver ignores line
        send(8'h5A, 1'b1, 1'b1);
        chk_reg("R12 disabled status", 2'd1, 32'h0);
        chk_reg("R12 disabled buffer", 2'd2, 32'h0);

        // R1 R2 R5 R9: unpacked sweep over all byte values
        wr(2'd0, C_EN);
        for (int i = 0; i < 256; i++) begin
            logic f;
            f = i[0] ^ i[3];
            send(8'(i), f, 1'b1);
            check("R2 irq_rx", 32'(irq_rx), 32'h1);
            chk_reg("R5 status after word", 2'd1, 32'h1 | (32'(f) << 3));
            chk_reg("R1 buffer value", 2'd2, (32'(f) << 8) | 32'(i));
            check("R9 irq_addr cleared", 32'(irq_addr), 32'h0);
            chk_reg("R9 status after read", 2'd1, 32'h0);
        end

        // R1: short low pulse is not a start bit
        @(negedge clk); rx_line = 1'b0;
        repeat (4) @(negedge clk); rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk_reg("R1 glitch status", 2'd1, 32'h0);

        // R3: filter drops data frames, passes addresses
        wr(2'd0, C_FILT);
        send(8'h33, 1'b0, 1'b1);
        chk_reg("R3 data dropped status", 2'd1, 32'h0);
        chk_reg("R3 buffer unchanged", 2'd2, 32'h0FF);
        send(8'h42, 1'b1, 1'b1);
        check("R5 irq_addr on address", 32'(irq_addr), 32'h1);
        chk_reg("R3 address status", 2'd1, 32'h9);
        chk_reg("R3 address buffer", 2'd2, 32'h142);

        // R4: filter off accepts both kinds
        wr(2'd0, C_EN);
        send(8'h17, 1'b0, 1'b1);
        chk_reg("R4 data status", 2'd1, 32'h1);
        chk_reg("R4 data buffer", 2'd2, 32'h017);
        send(8'h99, 1'b1, 1'b1);
        chk_reg("R4 address buffer", 2'd2, 32'h199);

        // R10: overrun and status-read clearing; R9 status read keeps data-ready
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1);
        chk_reg("R10 overrun status", 2'd1, 32'h3);
        chk_reg("R10 overrun cleared", 2'd1, 32'h1);
        chk_reg("R10 newer word kept", 2'd2, 32'h022);

        // R11: framing error
        send(8'h66, 1'b1, 1'b0);
        chk_reg("R11 framing status", 2'd1, 32'h4);
        chk_reg("R11 buffer unchanged", 2'd2, 32'h022);
        chk_reg("R11 framing cleared", 2'd1, 32'h0);

        // R6 R7 R8: packed mode with sync
        wr(2'd0, C_SYNC);
        chk_reg("R8 sync reads zero", 2'd0, 32'(C_PACK));
        send(8'hA5, 1'b1, 1'b1);
        chk_reg("R7 address in lower half", 2'd1, 32'h8);
        check("R5 irq_addr packed", 32'(irq_addr), 32'h1);
        send(8'h3C, 1'b0, 1'b1);
        chk_reg("R6 packed full status", 2'd1, 32'h9);
        chk_reg("R6 packed buffer", 2'd2, 32'h003C01A5);
        chk_reg("R9 packed read clears", 2'd1, 32'h0);
        send(8'h10, 1'b0, 1'b1);
        chk_reg("R6 half filled status", 2'd1, 32'h0);
        send(8'h7E, 1'b1, 1'b1);
        chk_reg("R7 address in upper half", 2'd1, 32'h9);
        chk_reg("R7 upper address buffer", 2'd2, 32'h017E0010);
        send(8'h55, 1'b0, 1'b1);
        wr(2'd0, C_SYNC);
        send(8'h01, 1'b0, 1'b1);
        chk_reg("R8 half word discarded", 2'd1, 32'h0);
        send(8'h02, 1'b1, 1'b1);
        chk_reg("R8 status after resync", 2'd1, 32'h9);
        chk_reg("R8 buffer after resync", 2'd2, 32'h01020001);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule